// File: doc/BRIEF.md
# Reset and Boot-Mode Sequencer

This block picks the operating mode of a chip after power-up or after an external reset. It synchronizes two active-low pins, a reset pin and a program-enable pin. It only accepts a reset whose low level lasts long enough. It then steps through a fixed startup order:

1. Request a load of the configuration table, which also sets the I/O directions.
2. Decide the mode from the pin levels held at the end of that load.
3. Hand control to a boot sequence, and then to the operational pair of states, active and doze.

The program-enable pin matters only while reset is held. With the pin asserted, the block enters flash emulation and normal operation stays off. With the pin negated, the block parks in a minimum-power hold until reset is released, and a normal boot follows. The configuration load and the boot are each a request/done handshake with a timeout. A timeout drops the block into the hold state, and it stays there until a fresh reset is accepted. Once running, the block moves to doze when the system reports idle, and back to active on pin activity.

Exactly one mode output is high at any time. The outputs are decoded from the state register, so each output changes on the clock edge that follows the input condition that causes it.

Top module: `boot_mode_seq`

## Requirements
- R1: While `arst_n` is low, and on its release, `cfg_req_o` is 1 and every other mode output is 0.
- R2: Both pins pass through a two-stage synchronizer. A reset-pin low level is accepted only after `RST_MIN_CYC` consecutive low synchronized samples. Shorter low pulses leave the mode unchanged.
- R3: When `cfg_done_i` is high while an accepted reset is held and the program-enable pin is low, the next state is flash emulation (`emu_en_o`).
- R4: When `cfg_done_i` is high while an accepted reset is held and the program-enable pin is high, the next state is hold (`hold_o`). Releasing reset then moves to boot (`boot_req_o`).
- R5: When `cfg_done_i` is high with no accepted reset, the next state is boot. `boot_done_i` high in boot moves to active (`active_o`).
- R6: A newly accepted reset moves boot, active, doze, emulation or a faulted hold back to the configuration load.
- R7: The program-enable pin has no effect outside the configuration decision. Toggling it in active, hold or emulation leaves the mode unchanged.
- R8: Active moves to doze when `idle_i` is 1 and `wake_i` is 0. Doze moves to active when `wake_i` is 1. Active stays active while `wake_i` is 1.
- R9: The configuration load and the boot each last at most `TMO_CYC` cycles without a done, and then move to hold. A hold reached by timeout does not boot on reset release. Only a new accepted reset leaves it.
- R10: `por_i` high moves any state to the configuration load on the next edge.
- R11: In emulation, release of the accepted reset moves to the configuration load. That load then leads to boot.
- R12: Exactly one of the six mode outputs is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| por_i | input | 1 | Power-on-reset flag, restarts the startup sequence |
| reset_pin_n | input | 1 | External reset pin, active low, asynchronous |
| prog_pin_n | input | 1 | Program-enable pin, active low, asynchronous, pulled high outside |
| cfg_done_i | input | 1 | Configuration table load finished |
| boot_done_i | input | 1 | Boot sequence finished |
| idle_i | input | 1 | CPU and all peripherals except the low-power timer are idle |
| wake_i | input | 1 | Activity seen on the serial or time-strobe pins |
| cfg_req_o | output | 1 | Configuration load requested |
| hold_o | output | 1 | Minimum-power hold |
| emu_en_o | output | 1 | Serial-flash emulation enabled |
| boot_req_o | output | 1 | Boot sequence requested |
| active_o | output | 1 | Operational, active |
| doze_o | output | 1 | Operational, doze |

## Verification
The properties assume that `cfg_done_i` and `boot_done_i` are single-cycle pulses given only while the matching request is high. They also assume that `por_i`, `idle_i` and `wake_i` are already synchronous to `clk`. Only the two pins are treated as asynchronous. The stimulus follows this: done pulses come one clock at a time from tasks that run only after the request has been observed, and all inputs change on the falling edge. Random reset-pin pulses are kept either well below or well above the acceptance width. This keeps every expected mode outside the one-cycle uncertainty that the synchronizer adds.

// File: rtl/bms_pkg.sv
package bms_pkg;

  typedef enum logic [2:0] {
    ST_CFG    = 3'd0,
    ST_HOLD   = 3'd1,
    ST_EMU    = 3'd2,
    ST_BOOT   = 3'd3,
    ST_ACTIVE = 3'd4,
    ST_DOZE   = 3'd5
  } bms_state_e;

  localparam int unsigned MODE_W = 6;

endpackage

// File: rtl/bms_sync.sv
module bms_sync #(
  parameter int unsigned      WIDTH   = 2,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/bms_rst_filter.sv
module bms_rst_filter #(
  parameter int unsigned MIN_CYC = 2500
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n_s,
  output logic qual
);

  localparam int unsigned CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          qual_q, qual_d;
  logic          upd_en;

  // count consecutive synchronized low samples; qualify on the MIN_CYC-th
  always_comb begin
    cnt_d  = cnt_q;
    qual_d = qual_q;
    if (pin_n_s) begin
      cnt_d  = '0;
      qual_d = 1'b0;
    end else if (!qual_q) begin
      if (cnt_q == CW'(MIN_CYC - 1)) qual_d = 1'b1;
      else                           cnt_d  = cnt_q + 1'b1;
    end
  end

  assign upd_en = (cnt_d != cnt_q) || (qual_d != qual_q);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      qual_q <= qual_d;
    end
  end

  assign qual = qual_q;

endmodule

// File: rtl/bms_fsm.sv
module bms_fsm
  import bms_pkg::*;
#(
  parameter int unsigned TMO_CYC = 4096
) (
  input  logic clk,
  input  logic arst_n,
  input  logic por,
  input  logic rst_qual,
  input  logic prog_act,
  input  logic cfg_done,
  input  logic boot_done,
  input  logic idle,
  input  logic wake,
  output logic cfg_req,
  output logic hold,
  output logic emu_en,
  output logic boot_req,
  output logic active,
  output logic doze
);

  localparam int unsigned TW = $clog2(TMO_CYC + 1);

  bms_state_e    state_q, state_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic          fault_q, fault_d;
  logic          rq_q;
  logic          rst_rise;
  logic          tmo_hit;
  logic          st_en, tmo_en, fault_en;

  assign rst_rise = rst_qual & ~rq_q;
  assign tmo_hit  = (tmo_q == TW'(TMO_CYC - 1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    tmo_d   = '0;
    fault_d = fault_q;
    if (por) begin
      state_d = ST_CFG;
      fault_d = 1'b0;
    end else if (rst_rise && (state_q != ST_CFG)) begin
      state_d = ST_CFG;
      fault_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_CFG: begin
          if (cfg_done) begin
            if (rst_qual) state_d = prog_act ? ST_EMU : ST_HOLD;
            else          state_d = ST_BOOT;
          end else if (tmo_hit) begin
            state_d = ST_HOLD;
            fault_d = 1'b1;
          end else begin
            tmo_d = tmo_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (!rst_qual && !fault_q) state_d = ST_BOOT;
        end
        ST_EMU: begin
          if (!rst_qual) begin
            state_d = ST_CFG;
            fault_d = 1'b0;
          end
        end
        ST_BOOT: begin
          if (boot_done) begin
            state_d = ST_ACTIVE;
          end else if (tmo_hit) begin
            state_d = ST_HOLD;
            fault_d = 1'b1;
          end else begin
            tmo_d = tmo_q + 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (idle && !wake) state_d = ST_DOZE;
        end
        ST_DOZE: begin
          if (wake) state_d = ST_ACTIVE;
        end
        default: begin
          state_d = ST_CFG;
          fault_d = 1'b0;
        end
      endcase
    end
  end

  assign st_en    = (state_d != state_q);
  assign tmo_en   = (tmo_d != tmo_q);
  assign fault_en = (fault_d != fault_q);

  // register process
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_CFG;
      tmo_q   <= '0;
      fault_q <= 1'b0;
      rq_q    <= 1'b0;
    end else begin
      if (st_en)    state_q <= state_d;
      if (tmo_en)   tmo_q   <= tmo_d;
      if (fault_en) fault_q <= fault_d;
      rq_q <= rst_qual;
    end
  end

  assign cfg_req  = (state_q == ST_CFG);
  assign hold     = (state_q == ST_HOLD);
  assign emu_en   = (state_q == ST_EMU);
  assign boot_req = (state_q == ST_BOOT);
  assign active   = (state_q == ST_ACTIVE);
  assign doze     = (state_q == ST_DOZE);

endmodule

// File: rtl/boot_mode_seq.sv
module boot_mode_seq
  import bms_pkg::*;
#(
  parameter int unsigned RST_MIN_CYC = 2500,
  parameter int unsigned TMO_CYC     = 4096,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic por_i,
  input  logic reset_pin_n,
  input  logic prog_pin_n,
  input  logic cfg_done_i,
  input  logic boot_done_i,
  input  logic idle_i,
  input  logic wake_i,
  output logic cfg_req_o,
  output logic hold_o,
  output logic emu_en_o,
  output logic boot_req_o,
  output logic active_o,
  output logic doze_o
);

  localparam int unsigned PIN_W = 2;

  logic [PIN_W-1:0] pin_s;
  logic             rst_pin_s;
  logic             prog_act;
  logic             rst_qual;

  bms_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({PIN_W{1'b1}})
  ) u_pin_sync (
    .clk   (clk),
    .arst_n(arst_n),
    .din   ({reset_pin_n, prog_pin_n}),
    .dout  (pin_s)
  );

  assign rst_pin_s = pin_s[1];
  assign prog_act  = ~pin_s[0];

  bms_rst_filter #(
    .MIN_CYC(RST_MIN_CYC)
  ) u_rst_filter (
    .clk    (clk),
    .arst_n (arst_n),
    .pin_n_s(rst_pin_s),
    .qual   (rst_qual)
  );

  bms_fsm #(
    .TMO_CYC(TMO_CYC)
  ) u_fsm (
    .clk      (clk),
    .arst_n   (arst_n),
    .por      (por_i),
    .rst_qual (rst_qual),
    .prog_act (prog_act),
    .cfg_done (cfg_done_i),
    .boot_done(boot_done_i),
    .idle     (idle_i),
    .wake     (wake_i),
    .cfg_req  (cfg_req_o),
    .hold     (hold_o),
    .emu_en   (emu_en_o),
    .boot_req (boot_req_o),
    .active   (active_o),
    .doze     (doze_o)
  );

endmodule

// File: rtl/bms_checker.sv
module bms_checker #(
  parameter int unsigned RST_MIN_CYC = 2500,
  parameter int unsigned TMO_CYC     = 4096
) (
  input logic clk,
  input logic arst_n,
  input logic por_i,
  input logic wake_i,
  input logic rst_pin_s,
  input logic rst_qual,
  input logic cfg_req_o,
  input logic hold_o,
  input logic emu_en_o,
  input logic boot_req_o,
  input logic active_o,
  input logic doze_o
);

  localparam int unsigned LW = $clog2(RST_MIN_CYC + 1);
  localparam int unsigned CW = $clog2(TMO_CYC + 1);

  logic [LW-1:0] lo_cnt;
  logic [CW-1:0] cfg_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      lo_cnt <= '0;
    end else if (rst_pin_s) begin
      lo_cnt <= '0;
    end else if (lo_cnt != LW'(RST_MIN_CYC)) begin
      lo_cnt <= lo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cfg_cnt <= '0;
    end else if (!cfg_req_o || por_i) begin
      cfg_cnt <= '0;
    end else if (cfg_cnt != CW'(TMO_CYC)) begin
      cfg_cnt <= cfg_cnt + 1'b1;
    end
  end

  p_one_mode_r12: assert property (@(posedge clk) disable iff (!arst_n)
    $countones({cfg_req_o, hold_o, emu_en_o, boot_req_o, active_o, doze_o}) == 1);

  p_por_restart_r10: assert property (@(posedge clk) disable iff (!arst_n)
    por_i |=> cfg_req_o);

  p_min_width_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_qual) |-> (lo_cnt >= LW'(RST_MIN_CYC)));

  p_emu_entry_r3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(emu_en_o) |-> $past(cfg_req_o));

  p_boot_entry_r4: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(boot_req_o) |-> ($past(cfg_req_o) || $past(hold_o)));

  p_active_entry_r5: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(active_o) |-> ($past(boot_req_o) || $past(doze_o)));

  p_doze_entry_r8: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(doze_o) |-> $past(active_o));

  p_doze_wake_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (doze_o && wake_i && !por_i && !rst_qual) |=> active_o);

  p_cfg_timeout_r9: assert property (@(posedge clk) disable iff (!arst_n)
    cfg_req_o |-> (cfg_cnt < CW'(TMO_CYC)));

  p_emu_exit_r11: assert property (@(posedge clk) disable iff (!arst_n)
    (emu_en_o && !rst_qual && !por_i) |=> cfg_req_o);

endmodule

bind boot_mode_seq bms_checker #(
  .RST_MIN_CYC(RST_MIN_CYC),
  .TMO_CYC    (TMO_CYC)
) u_bms_checker (
  .clk       (clk),
  .arst_n    (arst_n),
  .por_i     (por_i),
  .wake_i    (wake_i),
  .rst_pin_s (rst_pin_s),
  .rst_qual  (rst_qual),
  .cfg_req_o (cfg_req_o),
  .hold_o    (hold_o),
  .emu_en_o  (emu_en_o),
  .boot_req_o(boot_req_o),
  .active_o  (active_o),
  .doze_o    (doze_o)
);

// File: tb/boot_mode_seq_bench.sv
module boot_mode_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RMIN       = 8;
  localparam int TMO        = 40;

  localparam logic [5:0] M_CFG  = 6'b000001;
  localparam logic [5:0] M_HOLD = 6'b000010;
  localparam logic [5:0] M_EMU  = 6'b000100;
  localparam logic [5:0] M_BOOT = 6'b001000;
  localparam logic [5:0] M_ACT  = 6'b010000;
  localparam logic [5:0] M_DOZE = 6'b100000;

  logic clk;
  logic arst_n, por_i, reset_pin_n, prog_pin_n;
  logic cfg_done_i, boot_done_i, idle_i, wake_i;
  logic cfg_req_o, hold_o, emu_en_o, boot_req_o, active_o, doze_o;

  int n_chk  = 0;
  int n_fail = 0;

  boot_mode_seq #(
    .RST_MIN_CYC(RMIN),
    .TMO_CYC    (TMO)
  ) u_boot_mode_seq (
    .clk        (clk),
    .arst_n     (arst_n),
    .por_i      (por_i),
    .reset_pin_n(reset_pin_n),
    .prog_pin_n (prog_pin_n),
    .cfg_done_i (cfg_done_i),
    .boot_done_i(boot_done_i),
    .idle_i     (idle_i),
    .wake_i     (wake_i),
    .cfg_req_o  (cfg_req_o),
    .hold_o     (hold_o),
    .emu_en_o   (emu_en_o),
    .boot_req_o (boot_req_o),
    .active_o   (active_o),
    .doze_o     (doze_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // expected mode after a configuration decision
  function automatic logic [5:0] f_decide(input bit rst_held, input bit prog_low);
    if (!rst_held) return M_BOOT;
    return prog_low ? M_EMU : M_HOLD;
  endfunction

  // expected operational-pair transition
  function automatic logic [5:0] f_op_next(input logic [5:0] cur, input bit idle, input bit wake);
    if (cur == M_ACT && idle && !wake) return M_DOZE;
    if (cur == M_DOZE && wake)         return M_ACT;
    return cur;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_mode(input logic [5:0] exp, input string tag);
    logic [5:0] act;
    act = {doze_o, active_o, boot_req_o, emu_en_o, hold_o, cfg_req_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: mode actual=%b expected=%b", tag, act, exp);
    end
    n_chk++;
    if ($countones(act) != 1) begin
      n_fail++;
      $display("FAIL R12: mode actual=%b expected exactly one bit set", act);
    end
  endtask

  task automatic pulse_cfg();
    cfg_done_i = 1'b1;
    step(1);
    cfg_done_i = 1'b0;
  endtask

  task automatic pulse_boot();
    boot_done_i = 1'b1;
    step(1);
    boot_done_i = 1'b0;
  endtask

  task automatic assert_reset_pin();
    reset_pin_n = 1'b0;
    step(RMIN + 6);
  endtask

  task automatic release_reset_pin();
    reset_pin_n = 1'b1;
    step(6);
  endtask

  initial begin
    int unsigned seed_val;
    logic [5:0]  exp_m;
    seed_val = $urandom(32'd20240611);
    arst_n = 1'b0; por_i = 1'b0; reset_pin_n = 1'b1; prog_pin_n = 1'b1;
    cfg_done_i = 1'b0; boot_done_i = 1'b0; idle_i = 1'b0; wake_i = 1'b0;
    step(3);
    check_mode(M_CFG, "R1 during reset");
    arst_n = 1'b1;
    step(2);
    check_mode(M_CFG, "R1 after release");

    // normal startup
    pulse_cfg();
    check_mode(f_decide(1'b0, 1'b0), "R5 cfg without reset");
    pulse_boot();
    check_mode(M_ACT, "R5 boot done");

    // active / doze
    idle_i = 1'b1; wake_i = 1'b1; step(1);
    check_mode(M_ACT, "R8 wake keeps active");
    wake_i = 1'b0; step(1);
    check_mode(M_DOZE, "R8 idle enters doze");
    idle_i = 1'b0; step(3);
    check_mode(M_DOZE, "R8 doze holds without wake");
    wake_i = 1'b1; step(1);
    check_mode(M_ACT, "R8 wake leaves doze");
    wake_i = 1'b0;

    // program-enable outside reset
    prog_pin_n = 1'b0; step(10);
    check_mode(M_ACT, "R7 prog ignored in active");
    prog_pin_n = 1'b1; step(4);

    // glitch shorter than the minimum
    reset_pin_n = 1'b0; step(RMIN - 3);
    reset_pin_n = 1'b1; step(10);
    check_mode(M_ACT, "R2 short pulse ignored");

    // emulation path
    prog_pin_n = 1'b0;
    assert_reset_pin();
    check_mode(M_CFG, "R6 reset from active");
    pulse_cfg();
    check_mode(f_decide(1'b1, 1'b1), "R3 emulation entry");
    prog_pin_n = 1'b1; step(6);
    check_mode(M_EMU, "R7 prog release ignored in emulation");
    release_reset_pin();
    check_mode(M_CFG, "R11 emulation exit");
    pulse_cfg();
    check_mode(M_BOOT, "R11 boot after emulation");
    pulse_boot();
    check_mode(M_ACT, "R5 active after emulation");

    // hold path and boot timeout
    assert_reset_pin();
    check_mode(M_CFG, "R6 reset again");
    pulse_cfg();
    check_mode(f_decide(1'b1, 1'b0), "R4 hold entry");
    prog_pin_n = 1'b0; step(6);
    check_mode(M_HOLD, "R7 prog ignored in hold");
    prog_pin_n = 1'b1; step(4);
    release_reset_pin();
    check_mode(M_BOOT, "R4 release boots");
    step(TMO + 5);
    check_mode(M_HOLD, "R9 boot timeout");
    step(20);
    check_mode(M_HOLD, "R9 faulted hold stays");

    // config timeout while reset held
    assert_reset_pin();
    check_mode(M_CFG, "R6 reset leaves faulted hold");
    step(TMO + 5);
    check_mode(M_HOLD, "R9 cfg timeout");
    release_reset_pin();
    step(10);
    check_mode(M_HOLD, "R9 release ignored after timeout");

    // power-on reset
    por_i = 1'b1; step(1); por_i = 1'b0;
    check_mode(M_CFG, "R10 por from hold");
    pulse_cfg();
    pulse_boot();
    check_mode(M_ACT, "R5 boot after por");
    idle_i = 1'b1; step(1); idle_i = 1'b0;
    check_mode(M_DOZE, "R8 doze before por");
    por_i = 1'b1; step(1); por_i = 1'b0;
    check_mode(M_CFG, "R10 por from doze");
    pulse_cfg();
    pulse_boot();
    idle_i = 1'b1; step(1); idle_i = 1'b0;
    assert_reset_pin();
    check_mode(M_CFG, "R6 reset from doze");
    release_reset_pin();
    pulse_cfg();
    pulse_boot();
    check_mode(M_ACT, "R5 restart after doze reset");

    // random operational activity
    exp_m = M_ACT;
    for (int i = 0; i < 200; i++) begin
      idle_i = 1'($urandom % 2);
      wake_i = 1'($urandom % 2);
      step(1);
      exp_m = f_op_next(exp_m, idle_i, wake_i);
      check_mode(exp_m, "R8 random activity");
    end
    idle_i = 1'b0; wake_i = 1'b1; step(1); wake_i = 1'b0;
    check_mode(M_ACT, "R8 back to active");

    // random short glitches
    for (int i = 0; i < 5; i++) begin
      int w;
      w = 1 + int'($urandom % (RMIN - 3));
      reset_pin_n = 1'b0; step(w);
      reset_pin_n = 1'b1; step(8);
      check_mode(M_ACT, "R2 random short pulse");
    end

    // random decisions
    for (int i = 0; i < 6; i++) begin
      bit pl;
      pl = 1'($urandom % 2);
      prog_pin_n = ~pl;
      assert_reset_pin();
      check_mode(M_CFG, "R6 random reset accepted");
      pulse_cfg();
      check_mode(f_decide(1'b1, pl), pl ? "R3 random decision" : "R4 random decision");
      prog_pin_n = 1'b1;
      release_reset_pin();
      if (pl) begin
        check_mode(M_CFG, "R11 random emulation exit");
        pulse_cfg();
      end
      check_mode(M_BOOT, "R4 random boot");
      pulse_boot();
      check_mode(M_ACT, "R5 random active");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule